// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This is a 32-bit processor core that fetches, decodes and retires one instruction on every clock edge. It runs a small load/store subset: five register-to-register arithmetic and logic operations, a word load, a word store and a branch on equal. A combinational decoder turns the opcode and function field into a fixed set of control bits. Those bits steer the write-register select, the second ALU operand, the writeback source and the next-PC select.

The instruction memory and the data memory are separate and sit outside the core. The core shows the current PC on `imem_addr` and expects the instruction word back on `imem_data` in the same cycle. Data memory is also combinational on reads: the core presents a byte address and reads `dmem_rdata` in the same cycle. The memory writes `dmem_wdata` on the rising edge when `dmem_we` is high, and it decodes the address as a word index from bits [N:2]. Nothing here streams, so every pin is a plain level signal with no handshake.

A branch compares its two registers by subtracting them in the ALU. The branch is taken when the result is zero. A separate adder computes the target.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high, at each rising edge the PC is cleared to 0. `dmem_we` stays low, and no register is written.
- R2: An instruction that is not a taken branch sets the next PC to the current PC plus 4.
- R3: Branch-on-equal uses opcode 000100 with rs in [25:21], rt in [20:16] and a signed offset in [15:0]. When the two register values are equal, the next PC is PC + 4 + (sign-extended offset << 2). Otherwise the next PC is PC + 4.
- R4: Opcode 000000 is a register operation with rs [25:21], rt [20:16], rd [15:11] and func [5:0]. The func codes are add 100000, sub 100010, and 100100, or 100101, and slt 101010. slt is a signed comparison that gives 1 or 0. The result is written to rd.
- R5: A load uses opcode 100011. It drives `dmem_re` high and `dmem_addr` = rs + sign-extended [15:0], and it writes `dmem_rdata` into rt.
- R6: A store uses opcode 101011. It drives `dmem_we` high, `dmem_addr` = rs + sign-extended [15:0] and `dmem_wdata` = rt. `dmem_we` and `dmem_re` are never high together.
- R7: Register 0 always reads as zero, and a write to it has no effect.
- R8: Any other opcode, or a register operation with any other func code, writes neither a register nor memory.
- R9: A branch-on-equal drives neither `dmem_we` nor `dmem_re`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 32 | Byte address of the current instruction (the PC) |
| imem_data | input | 32 | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | 32 | Data memory byte address |
| dmem_re | output | 1 | Load in progress |
| dmem_rdata | input | 32 | Data word at `dmem_addr`, same cycle |
| dmem_we | output | 1 | Store strobe, taken on the rising edge |
| dmem_wdata | output | 32 | Store data |

## Verification
The assertions assume that `imem_data` and `dmem_rdata` are settled, known values that depend only on the addresses presented in the same cycle. They also assume that `rst` changes only away from the clock edge. The bench drives both memories from plain arrays read combinationally by address, so no read ever returns an unknown value. It wraps instruction fetch at 256 words and data access at 64 words, so every address a random program produces maps to an initialized word. Random branch offsets are forward only, between 0 and 5 words, so the instruction stream never lands in a one-instruction loop.

// File: rtl/sc_pkg.sv
`timescale 1ns/1ps
package sc_pkg;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_op_e;

  localparam logic [5:0] OPC_REG   = 6'b000000;
  localparam logic [5:0] OPC_LOAD  = 6'b100011;
  localparam logic [5:0] OPC_STORE = 6'b101011;
  localparam logic [5:0] OPC_BREQ  = 6'b000100;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef struct packed {
    logic    wr_sel_rd;   // 1: destination is rd, 0: rt
    logic    reg_wr;
    logic    opb_imm;     // 1: second ALU operand is the immediate
    logic    mem_wr;
    logic    mem_rd;
    logic    wb_from_mem; // 1: writeback takes the load data
    logic    is_branch;
    alu_op_e alu_op;
  } ctrl_t;

endpackage

// File: rtl/sc_decoder.sv
`timescale 1ns/1ps
module sc_decoder
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] func,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl = '{wr_sel_rd: 1'b0, reg_wr: 1'b0, opb_imm: 1'b0, mem_wr: 1'b0,
             mem_rd: 1'b0, wb_from_mem: 1'b0, is_branch: 1'b0, alu_op: ALU_ADD};
    unique case (opcode)
      OPC_REG: begin
        ctrl.wr_sel_rd = 1'b1;
        ctrl.reg_wr    = 1'b1;
        case (func)
          FN_ADD:  ctrl.alu_op = ALU_ADD;
          FN_SUB:  ctrl.alu_op = ALU_SUB;
          FN_AND:  ctrl.alu_op = ALU_AND;
          FN_OR:   ctrl.alu_op = ALU_OR;
          FN_SLT:  ctrl.alu_op = ALU_SLT;
          default: ctrl.reg_wr = 1'b0; // unknown func: no-op
        endcase
      end
      OPC_LOAD: begin
        ctrl.reg_wr      = 1'b1;
        ctrl.opb_imm     = 1'b1;
        ctrl.mem_rd      = 1'b1;
        ctrl.wb_from_mem = 1'b1;
      end
      OPC_STORE: begin
        ctrl.opb_imm = 1'b1;
        ctrl.mem_wr  = 1'b1;
      end
      OPC_BREQ: begin
        ctrl.is_branch = 1'b1;
        ctrl.alu_op    = ALU_SUB;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/sc_regfile.sv
`timescale 1ns/1ps
module sc_regfile #(
  parameter int XLEN  = 32,
  parameter int NREGS = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [$clog2(NREGS)-1:0] ra1,
  input  logic [$clog2(NREGS)-1:0] ra2,
  output logic [XLEN-1:0]          rd1,
  output logic [XLEN-1:0]          rd2,
  input  logic                     we,
  input  logic [$clog2(NREGS)-1:0] wa,
  input  logic [XLEN-1:0]          wd
);
  localparam int AW = $clog2(NREGS);

  logic [XLEN-1:0] regs [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign regs[g] = '0;
    end else begin : g_store
      logic [XLEN-1:0] q;
      always_ff @(posedge clk) begin
        if (rst)                         q <= '0;
        else if (we && wa == AW'(g))     q <= wd;
      end
      assign regs[g] = q;
    end
  end

  assign rd1 = regs[ra1];
  assign rd2 = regs[ra2];

  // A write to a nonzero register is visible on the next cycle (R4)
  p_write_lands_r4: assert property (@(posedge clk) disable iff (rst)
    (we && wa != '0) |=> regs[$past(wa)] == $past(wd));

  // Register 0 stays zero even after a write aimed at it (R7)
  p_zero_holds_r7: assert property (@(posedge clk) disable iff (rst)
    (we && wa == '0) |=> regs[0] == '0);

endmodule

// File: rtl/sc_alu.sv
`timescale 1ns/1ps
module sc_alu
  import sc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  alu_op_e         op,
  output logic [XLEN-1:0] y,
  output logic            zero
);

  logic [XLEN-1:0] diff;
  assign diff = a - b;

  always_comb begin
    unique case (op)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_ADD: y = a + b;
      ALU_SUB: y = diff;
      ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/sc_core.sv
`timescale 1ns/1ps
module sc_core
  import sc_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NREGS = 32
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] imem_addr,
  input  logic [31:0]     imem_data,
  output logic [XLEN-1:0] dmem_addr,
  output logic            dmem_re,
  input  logic [XLEN-1:0] dmem_rdata,
  output logic            dmem_we,
  output logic [XLEN-1:0] dmem_wdata
);
  localparam int AW  = $clog2(NREGS);
  localparam int IMM = 16;

  logic [XLEN-1:0] pc_q, pc_next, pc_plus4, br_target, imm_ext;
  logic [5:0]      f_op, f_fn;
  logic [4:0]      f_rs, f_rt, f_rd;
  logic [IMM-1:0]  f_imm;
  ctrl_t           ctrl;
  logic [AW-1:0]   wr_reg;
  logic [XLEN-1:0] rs_val, rt_val, opb, alu_y, wb_val;
  logic            alu_zero, pc_src, rf_we;

  assign f_op  = imem_data[31:26];
  assign f_rs  = imem_data[25:21];
  assign f_rt  = imem_data[20:16];
  assign f_rd  = imem_data[15:11];
  assign f_fn  = imem_data[5:0];
  assign f_imm = imem_data[15:0];

  sc_decoder u_dec (
    .opcode (f_op),
    .func   (f_fn),
    .ctrl   (ctrl)
  );

  assign imm_ext = {{(XLEN-IMM){f_imm[IMM-1]}}, f_imm};
  assign wr_reg  = ctrl.wr_sel_rd ? f_rd[AW-1:0] : f_rt[AW-1:0];
  assign rf_we   = ctrl.reg_wr & ~rst;

  sc_regfile #(.XLEN(XLEN), .NREGS(NREGS)) u_rf (
    .clk (clk),
    .rst (rst),
    .ra1 (f_rs[AW-1:0]),
    .ra2 (f_rt[AW-1:0]),
    .rd1 (rs_val),
    .rd2 (rt_val),
    .we  (rf_we),
    .wa  (wr_reg),
    .wd  (wb_val)
  );

  assign opb = ctrl.opb_imm ? imm_ext : rt_val;

  sc_alu #(.XLEN(XLEN)) u_alu (
    .a    (rs_val),
    .b    (opb),
    .op   (ctrl.alu_op),
    .y    (alu_y),
    .zero (alu_zero)
  );

  assign wb_val = ctrl.wb_from_mem ? dmem_rdata : alu_y;

  // next PC: sequential adder and a separate branch-target adder
  assign pc_plus4  = pc_q + XLEN'(4);
  assign br_target = pc_plus4 + (imm_ext << 2);
  assign pc_src    = ctrl.is_branch & alu_zero;
  assign pc_next   = pc_src ? br_target : pc_plus4;

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  assign imem_addr  = pc_q;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_val;
  assign dmem_we    = ctrl.mem_wr & ~rst;
  assign dmem_re    = ctrl.mem_rd;

  // independent recognition of legal encodings for the checks below
  logic legal_ins;
  always_comb begin
    legal_ins = (f_op == OPC_LOAD) || (f_op == OPC_STORE) || (f_op == OPC_BREQ);
    if (f_op == OPC_REG)
      legal_ins = (f_fn == FN_ADD) || (f_fn == FN_SUB) || (f_fn == FN_AND) ||
                  (f_fn == FN_OR)  || (f_fn == FN_SLT);
  end

  p_reset_pc_r1: assert property (@(posedge clk)
    rst |=> pc_q == '0);

  p_reset_nostore_r1: assert property (@(posedge clk)
    rst |-> !dmem_we && !rf_we);

  p_step_pc_r2: assert property (@(posedge clk) disable iff (rst)
    !pc_src |=> pc_q == $past(pc_q) + XLEN'(4));

  p_branch_pc_r3: assert property (@(posedge clk) disable iff (rst)
    pc_src |=> pc_q == $past(pc_q) + XLEN'(4) + ($past(imm_ext) << 2));

  p_branch_eq_r3: assert property (@(posedge clk) disable iff (rst)
    (f_op == OPC_BREQ) |-> (pc_src == (rs_val == rt_val)));

  p_mem_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(dmem_we && dmem_re));

  p_zero_src_r7: assert property (@(posedge clk) disable iff (rst)
    (f_rs == 5'd0) |-> rs_val == '0);

  p_unknown_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !legal_ins |-> !dmem_we && !rf_we);

  p_branch_nomem_r9: assert property (@(posedge clk) disable iff (rst)
    (f_op == OPC_BREQ) |-> !dmem_we && !dmem_re && !rf_we);

endmodule

// File: tb/tb_sc_core.sv
`timescale 1ns/1ps
module tb_sc_core;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_rdata, dmem_wdata;
  logic        dmem_re, dmem_we;

  always #2 clk = ~clk; // 250 MHz

  logic [31:0] imem [256];
  logic [31:0] bmem [64];

  assign imem_data  = imem[imem_addr[9:2]];
  assign dmem_rdata = bmem[dmem_addr[7:2]];
  always @(posedge clk) if (dmem_we) bmem[dmem_addr[7:2]] <= dmem_wdata;

  sc_core dut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_re(dmem_re), .dmem_rdata(dmem_rdata),
    .dmem_we(dmem_we), .dmem_wdata(dmem_wdata)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state
  logic [31:0] mreg [32];
  logic [31:0] mmem [64];
  logic [31:0] mpc;
  string       tag  [32];
  bit          last_taken;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic logic [31:0] enc_r(input int rs, rt, rd, input logic [5:0] fn);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, rt,
                                        input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  function automatic bit fn_ok(input logic [5:0] fn);
    return fn == 6'b100000 || fn == 6'b100010 || fn == 6'b100100 ||
           fn == 6'b100101 || fn == 6'b101010;
  endfunction

  function automatic logic [31:0] ref_alu(input logic [5:0] fn, input logic [31:0] a, b);
    case (fn)
      6'b100000: return a + b;
      6'b100010: return a - b;
      6'b100100: return a & b;
      6'b100101: return a | b;
      default:   return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
    endcase
  endfunction

  // compare outputs for the current instruction, then advance the model
  task automatic check_and_step();
    logic [31:0] ins, a, b, ea;
    logic [5:0]  op;
    int          rs, rt, rd;
    ins = imem[mpc[9:2]];
    op = ins[31:26]; rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
    a = mreg[rs]; b = mreg[rt]; ea = a + sx(ins[15:0]);
    chk(last_taken ? "R3" : "R2", "pc", imem_addr, mpc);
    case (op)
      6'b101011: begin
        chk("R6", "store we", 32'(dmem_we), 32'd1);
        chk("R6", "store re", 32'(dmem_re), 32'd0);
        chk("R6", "store addr", dmem_addr, ea);
        chk(tag[rt], "store data", dmem_wdata, b);
        mmem[ea[7:2]] = b;
        last_taken = 0;
      end
      6'b100011: begin
        chk("R5", "load re", 32'(dmem_re), 32'd1);
        chk("R5", "load addr", dmem_addr, ea);
        if (rt != 0) begin mreg[rt] = mmem[ea[7:2]]; tag[rt] = "R5"; end
        last_taken = 0;
      end
      6'b000100: begin
        chk("R9", "branch mem", {30'd0, dmem_we, dmem_re}, 32'd0);
        last_taken = (a == b);
      end
      6'b000000: begin
        if (fn_ok(ins[5:0])) begin
          chk("R4", "reg-op we", 32'(dmem_we), 32'd0);
          if (rd != 0) begin mreg[rd] = ref_alu(ins[5:0], a, b); tag[rd] = "R4"; end
        end else begin
          chk("R8", "bad func we", 32'(dmem_we), 32'd0);
        end
        last_taken = 0;
      end
      default: begin
        chk("R8", "bad opcode mem", {30'd0, dmem_we, dmem_re}, 32'd0);
        last_taken = 0;
      end
    endcase
    mpc = last_taken ? mpc + 32'd4 + (sx(ins[15:0]) << 2) : mpc + 32'd4;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) begin bmem[i] = $urandom; mmem[i] = bmem[i]; end
    bmem[0] = 32'h8000_0005; mmem[0] = bmem[0]; // negative, exercises signed slt
    bmem[1] = 32'h0000_0007; mmem[1] = bmem[1];
    for (int i = 0; i < 32; i++) begin mreg[i] = '0; tag[i] = "R7"; end
    // directed prologue
    imem[0]  = enc_i(6'b100011, 0, 1, 16'd0);
    imem[1]  = enc_i(6'b100011, 0, 2, 16'd4);
    imem[2]  = enc_r(1, 2, 3, 6'b100000);
    imem[3]  = enc_i(6'b101011, 0, 3, 16'd8);
    imem[4]  = enc_i(6'b000100, 0, 0, 16'd1);     // taken, skips 5
    imem[5]  = enc_i(6'b101011, 0, 1, 16'd12);
    imem[6]  = enc_r(1, 2, 4, 6'b100010);
    imem[7]  = enc_r(1, 2, 5, 6'b101010);
    imem[8]  = enc_r(1, 2, 6, 6'b100100);
    imem[9]  = enc_r(1, 2, 7, 6'b100101);
    imem[10] = enc_r(1, 2, 0, 6'b100000);         // write to register 0
    imem[11] = enc_i(6'b101011, 0, 0, 16'd16);
    imem[12] = enc_i(6'b101011, 0, 4, 16'd20);
    imem[13] = enc_i(6'b101011, 0, 5, 16'd24);
    imem[14] = enc_i(6'b101011, 0, 6, 16'd28);
    imem[15] = enc_i(6'b101011, 0, 7, 16'd32);
    imem[16] = {6'b111111, 26'h155_5555};          // unknown opcode
    imem[17] = enc_r(1, 2, 3, 6'b000001);          // unknown func
    imem[18] = enc_i(6'b101011, 0, 3, 16'd36);
    imem[19] = enc_i(6'b000100, 1, 2, 16'd5);      // not taken
    imem[20] = enc_i(6'b100011, 0, 8, 16'hFFFC);   // negative offset
    imem[21] = enc_i(6'b101011, 0, 8, 16'd40);
    for (int i = 22; i < 256; i++) begin
      int k;
      k = int'($urandom_range(0, 9));
      if (k <= 3) begin
        logic [5:0] fl [5] = '{6'b100000, 6'b100010, 6'b100100, 6'b100101, 6'b101010};
        imem[i] = enc_r(int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
                        int'($urandom_range(0, 7)), fl[$urandom_range(0, 4)]);
      end else if (k <= 5)
        imem[i] = enc_i(6'b100011, int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
                        16'($urandom_range(0, 255)) & 16'hFFFC);
      else if (k <= 7)
        imem[i] = enc_i(6'b101011, int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
                        16'($urandom_range(0, 255)) & 16'hFFFC);
      else if (k == 8)
        imem[i] = enc_i(6'b000100, int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
                        16'($urandom_range(0, 5)));
      else
        imem[i] = {6'b110011, 26'($urandom)};
    end
    mpc = 0; last_taken = 0;

    // reset phase (R1)
    for (int c = 0; c < 3; c++) begin
      @(negedge clk); #0.5;
      chk("R1", "reset pc", imem_addr, 32'd0);
      chk("R1", "reset we", 32'(dmem_we), 32'd0);
    end
    rst = 1'b0;
    #0.5;
    for (int c = 0; c < 3000; c++) begin
      check_and_step();
      @(negedge clk); #0.5;
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule